// File: doc/BRIEF.md
# Jiffy Tick Timer

This block divides the system clock down to a periodic jiffy tick, typically one every 10 ms (100 per second). Each tick advances a free-running uptime count and steps down a delay count that software loads to time an interval. Every tick also raises a level interrupt request, which software clears with an acknowledge pulse.

Software starts a delay by writing a value into the delay counter. It then either polls the counter until it reaches zero or watches the sticky done flag. The uptime counter serves as a monotonic time base that rolls over and never stops. The number of clock cycles per tick is a parameter, so one design covers any system clock rate.

Top module: `jiffy_timer`

## Requirements
- R1: `tick` is a single-cycle pulse once every `DIVIDE` clock cycles. The first pulse follows the `DIVIDE`-th rising edge after reset is released.
- R2: `uptime_q` rises by exactly one on the edge that raises `tick` and holds its value on every other edge.
- R3: `uptime_q` wraps from all ones to zero and keeps counting.
- R4: `irq` goes high on every tick. It stays high until `irq_ack` is sampled high on an edge that is not a tick edge. When a tick and an acknowledge fall on the same edge, `irq` stays high.
- R5: Ticks that arrive while `irq` is already high do not queue. A single acknowledge clears `irq` even after several ticks.
- R6: When `delay_load` is high at an edge, `delay_q` takes the value of `delay_wdata` and `delay_done` is cleared. If that edge is also a tick edge, the load wins and no decrement takes place.
- R7: On a tick edge without a load, `delay_q` drops by one if it is non-zero. At zero it holds zero and never wraps.
- R8: `delay_done` is set when a tick takes `delay_q` from 1 to 0. It stays set across later ticks until the next load. Loading zero leaves `delay_done` clear.
- R9: When `rst` is high at an edge, the following are all cleared: the prescaler phase, `tick`, `uptime_q`, `delay_q`, `delay_done` and `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| delay_load | input | 1 | Write strobe for the delay counter |
| delay_wdata | input | DELAY_W | Value loaded into the delay counter |
| irq_ack | input | 1 | Acknowledge, clears the interrupt request |
| tick | output | 1 | One-cycle jiffy pulse |
| irq | output | 1 | Level interrupt request |
| uptime_q | output | UPTIME_W | Free-running uptime count |
| delay_q | output | DELAY_W | Current delay count |
| delay_done | output | 1 | Sticky flag: delay expired |

## Verification
The uptime wrap can't be reached from the ports at full width, because that would take 2^32 ticks. The bench therefore runs a second instance with a 4-bit uptime counter and a divide ratio of two, and it checks the roll from 15 to 0 right after a reset. The other hard case is the race on a tick edge: a load or an acknowledge that lands on the very edge that carries a tick. The bench syncs to an observed tick and waits exactly `DIVIDE-1` cycles before it drives the strobe, so the strobe lands on the next tick edge.

// File: rtl/jiffy_pkg.sv
package jiffy_pkg;

   // Operation applied to the delay counter on a given edge
   typedef enum logic [1:0] {
      DLY_HOLD = 2'd0,
      DLY_LOAD = 2'd1,
      DLY_STEP = 2'd2
   } dly_op_e;

   // Width of a counter that spans 0 .. n-1, at least one bit
   function automatic int span_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/jiffy_prescaler.sv
module jiffy_prescaler #(
   parameter int DIVIDE = 100000
) (
   input  logic clk,
   input  logic rst,
   output logic step,
   output logic tick
);
   localparam int CNT_W = jiffy_pkg::span_width(DIVIDE);

   generate
      if (DIVIDE == 1) begin : g_passthru
         // Every clock is a jiffy
         assign step = 1'b1;
      end else begin : g_divider
         localparam logic [CNT_W-1:0] LAST = CNT_W'(DIVIDE - 1);
         logic [CNT_W-1:0] phase;

         assign step = (phase == LAST);

         always_ff @(posedge clk) begin
            if (rst)       phase <= '0;
            else if (step) phase <= '0;
            else           phase <= phase + 1'b1;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) tick <= 1'b0;
      else     tick <= step;
   end

endmodule

// File: rtl/jiffy_uptime.sv
module jiffy_uptime #(
   parameter int UPTIME_W = 32
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                step,
   output logic [UPTIME_W-1:0] count
);

   always_ff @(posedge clk) begin
      if (rst)       count <= '0;
      else if (step) count <= count + 1'b1;
   end

endmodule

// File: rtl/jiffy_delay.sv
module jiffy_delay #(
   parameter int DELAY_W = 16
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               step,
   input  logic               load,
   input  logic [DELAY_W-1:0] wdata,
   output logic [DELAY_W-1:0] count,
   output logic               done
);
   import jiffy_pkg::*;

   localparam logic [DELAY_W-1:0] ONE = DELAY_W'(1);

   dly_op_e op;
   logic    nonzero;

   assign nonzero = |count;

   always_comb begin
      if (load)                 op = DLY_LOAD;
      else if (step && nonzero) op = DLY_STEP;
      else                      op = DLY_HOLD;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         count <= '0;
         done  <= 1'b0;
      end else begin
         case (op)
            DLY_LOAD: begin
               count <= wdata;
               done  <= 1'b0;
            end
            DLY_STEP: begin
               count <= count - 1'b1;
               if (count == ONE) done <= 1'b1;
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/jiffy_irq.sv
module jiffy_irq (
   input  logic clk,
   input  logic rst,
   input  logic step,
   input  logic ack,
   output logic req
);

   always_ff @(posedge clk) begin
      if (rst)       req <= 1'b0;
      else if (step) req <= 1'b1;
      else if (ack)  req <= 1'b0;
   end

endmodule

// File: rtl/jiffy_timer.sv
module jiffy_timer #(
   parameter int DIVIDE   = 100000,
   parameter int UPTIME_W = 32,
   parameter int DELAY_W  = 16
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                delay_load,
   input  logic [DELAY_W-1:0]  delay_wdata,
   input  logic                irq_ack,
   output logic                tick,
   output logic                irq,
   output logic [UPTIME_W-1:0] uptime_q,
   output logic [DELAY_W-1:0]  delay_q,
   output logic                delay_done
);

   generate
      if (DIVIDE < 1) begin : g_bad_divide
         $error("jiffy_timer: DIVIDE must be at least 1");
      end
      if (UPTIME_W < 2) begin : g_bad_uptime
         $error("jiffy_timer: UPTIME_W must be at least 2");
      end
      if (DELAY_W < 2) begin : g_bad_delay
         $error("jiffy_timer: DELAY_W must be at least 2");
      end
   endgenerate

   logic step;

   jiffy_prescaler #(.DIVIDE(DIVIDE)) u_prescale (
      .clk  (clk),
      .rst  (rst),
      .step (step),
      .tick (tick)
   );

   jiffy_uptime #(.UPTIME_W(UPTIME_W)) u_uptime (
      .clk   (clk),
      .rst   (rst),
      .step  (step),
      .count (uptime_q)
   );

   jiffy_delay #(.DELAY_W(DELAY_W)) u_delay (
      .clk   (clk),
      .rst   (rst),
      .step  (step),
      .load  (delay_load),
      .wdata (delay_wdata),
      .count (delay_q),
      .done  (delay_done)
   );

   jiffy_irq u_irq (
      .clk  (clk),
      .rst  (rst),
      .step (step),
      .ack  (irq_ack),
      .req  (irq)
   );

endmodule

// File: rtl/jiffy_timer_checker.sv
module jiffy_timer_checker #(
   parameter int DIVIDE   = 100000,
   parameter int UPTIME_W = 32,
   parameter int DELAY_W  = 16
) (
   input logic                clk,
   input logic                rst,
   input logic                delay_load,
   input logic [DELAY_W-1:0]  delay_wdata,
   input logic                irq_ack,
   input logic                tick,
   input logic                irq,
   input logic [UPTIME_W-1:0] uptime_q,
   input logic [DELAY_W-1:0]  delay_q,
   input logic                delay_done
);
   // High once the previous edge was taken out of reset
   logic armed;
   always_ff @(posedge clk) armed <= !rst;

   generate
      if (DIVIDE > 1) begin : g_pulse
         assert_tick_pulse_R1: assert property (@(posedge clk) disable iff (rst)
            tick |=> !tick);
      end
   endgenerate

   assert_uptime_step_R2: assert property (@(posedge clk) disable iff (rst || !armed)
      tick |-> uptime_q == UPTIME_W'($past(uptime_q) + 1'b1));

   assert_uptime_hold_R2: assert property (@(posedge clk) disable iff (rst || !armed)
      !tick |-> $stable(uptime_q));

   assert_irq_on_tick_R4: assert property (@(posedge clk) disable iff (rst)
      tick |-> irq);

   assert_irq_sticky_R4: assert property (@(posedge clk) disable iff (rst)
      (irq && !irq_ack) |=> irq);

   assert_load_value_R6: assert property (@(posedge clk) disable iff (rst)
      delay_load |=> (delay_q == $past(delay_wdata)) && !delay_done);

   assert_delay_step_R7: assert property (@(posedge clk) disable iff (rst || !armed)
      (tick && !$past(delay_load) && $past(delay_q) != '0)
         |-> delay_q == DELAY_W'($past(delay_q) - 1'b1));

   assert_delay_floor_R7: assert property (@(posedge clk) disable iff (rst || !armed)
      (!$past(delay_load) && $past(delay_q) == '0) |-> delay_q == '0);

   assert_done_at_zero_R8: assert property (@(posedge clk) disable iff (rst)
      delay_done |-> delay_q == '0);

endmodule

bind jiffy_timer jiffy_timer_checker #(
   .DIVIDE   (DIVIDE),
   .UPTIME_W (UPTIME_W),
   .DELAY_W  (DELAY_W)
) u_chk (.*);

// File: tb/jiffy_timer_test.sv
module jiffy_timer_test;
   localparam int  CLK_PERIOD = 10;
   localparam int  DIV        = 5;
   localparam int  NDIV       = 2;
   localparam int  NUP_W      = 4;
   localparam int  NVEC       = 7;

   // Each vector: {load value[15:0], ticks to wait[7:0]}
   localparam logic [23:0] VEC [NVEC] = '{
      {16'd3,   8'd1},
      {16'd3,   8'd3},
      {16'd3,   8'd5},
      {16'd1,   8'd1},
      {16'd0,   8'd2},
      {16'd100, 8'd4},
      {16'd2,   8'd2}
   };

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        delay_load = 1'b0;
   logic [15:0] delay_wdata = '0;
   logic        irq_ack = 1'b0;
   logic        tick, irq, delay_done;
   logic [31:0] uptime_q;
   logic [15:0] delay_q;

   logic             n_tick, n_irq, n_done;
   logic [NUP_W-1:0] n_uptime;
   logic [15:0]      n_delay;

   int checks = 0;
   int fails  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   jiffy_timer #(.DIVIDE(DIV), .UPTIME_W(32), .DELAY_W(16)) uut (
      .clk(clk), .rst(rst), .delay_load(delay_load), .delay_wdata(delay_wdata),
      .irq_ack(irq_ack), .tick(tick), .irq(irq), .uptime_q(uptime_q),
      .delay_q(delay_q), .delay_done(delay_done)
   );

   jiffy_timer #(.DIVIDE(NDIV), .UPTIME_W(NUP_W), .DELAY_W(16)) uut_narrow (
      .clk(clk), .rst(rst), .delay_load(1'b0), .delay_wdata(16'd0),
      .irq_ack(1'b0), .tick(n_tick), .irq(n_irq), .uptime_q(n_uptime),
      .delay_q(n_delay), .delay_done(n_done)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wait_tick();
      do @(negedge clk); while (!tick);
   endtask

   task automatic wait_narrow_tick();
      do @(negedge clk); while (!n_tick);
   endtask

   task automatic load_delay(input logic [15:0] v);
      delay_load  = 1'b1;
      delay_wdata = v;
      @(negedge clk);
      delay_load  = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      int k;
      logic [31:0] up0;
      repeat (3) @(negedge clk);
      // R9: reset state
      check("R9 tick",   {31'd0, tick}, 0);
      check("R9 irq",    {31'd0, irq}, 0);
      check("R9 uptime", uptime_q, 0);
      check("R9 delay",  {16'd0, delay_q}, 0);
      check("R9 done",   {31'd0, delay_done}, 0);
      rst = 1'b0;

      // R1: first tick after DIV edges
      k = 0;
      do begin @(posedge clk); k++; @(negedge clk); end while (!tick);
      check("R1 first tick edge", k, DIV);
      check("R2 uptime at first tick", uptime_q, 1);
      check("R4 irq after tick", {31'd0, irq}, 1);
      // R1: period and single-cycle width
      k = 0;
      do begin @(negedge clk); k++;
         if (k == 1) check("R1 tick width", {31'd0, tick}, 0);
         if (k == 2) check("R2 uptime holds", uptime_q, 1);
      end while (!tick);
      check("R1 tick period", k, DIV);
      check("R2 uptime at second tick", uptime_q, 2);

      // R5: two ticks pending, one ack clears
      check("R5 irq still pending", {31'd0, irq}, 1);
      irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
      check("R5 single ack clears", {31'd0, irq}, 0);
      // R4: without ack the request stays
      wait_tick();
      repeat (3) @(negedge clk);
      check("R4 irq held without ack", {31'd0, irq}, 1);
      // R4: ack landing on a tick edge leaves irq set
      @(negedge clk);               // next edge is the tick edge
      irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
      check("R4 tick seen", {31'd0, tick}, 1);
      check("R4 ack on tick edge keeps irq", {31'd0, irq}, 1);
      irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;

      // Table: R6 R7 R8 load, count down, floor, done
      for (int i = 0; i < NVEC; i++) begin
         logic [15:0] v;
         int n, expv, expd;
         v = VEC[i][23:8];
         n = int'(VEC[i][7:0]);
         wait_tick();
         load_delay(v);
         check("R6 load value", {16'd0, delay_q}, {16'd0, v});
         check("R6 load clears done", {31'd0, delay_done}, 0);
         for (int t = 0; t < n; t++) wait_tick();
         expv = (int'(v) > n) ? int'(v) - n : 0;
         expd = (v != 0 && n >= int'(v)) ? 1 : 0;
         check("R7 delay after ticks", {16'd0, delay_q}, expv);
         check("R8 done after ticks", {31'd0, delay_done}, expd);
      end

      // R8: done stays set across further ticks
      wait_tick();
      check("R8 done sticky", {31'd0, delay_done}, 1);
      check("R7 floor at zero", {16'd0, delay_q}, 0);
      // R6: load on a tick edge wins over decrement and clears done
      wait_tick();
      repeat (DIV - 1) @(negedge clk);
      up0 = uptime_q;
      load_delay(16'd7);
      check("R6 tick on load edge", {31'd0, tick}, 1);
      check("R2 uptime advanced", uptime_q, up0 + 1);
      check("R6 load beats tick", {16'd0, delay_q}, 7);
      check("R6 done cleared", {31'd0, delay_done}, 0);

      // R9: mid-run reset
      rst = 1'b1; @(negedge clk); rst = 1'b0;
      check("R9 uptime cleared", uptime_q, 0);
      check("R9 delay cleared", {16'd0, delay_q}, 0);
      check("R9 irq cleared", {31'd0, irq}, 0);
      // R9: prescaler phase cleared, full period follows
      k = 0;
      do begin @(negedge clk); k++; end while (!tick);
      check("R9 prescaler restarts", k, DIV);

      // R3: narrow instance wraps 15 -> 0
      rst = 1'b1; @(negedge clk); rst = 1'b0;
      for (int t = 0; t < 15; t++) wait_narrow_tick();
      check("R3 narrow at all ones", {28'd0, n_uptime}, 15);
      wait_narrow_tick();
      check("R3 narrow wrapped", {28'd0, n_uptime}, 0);
      wait_narrow_tick();
      check("R3 counts on after wrap", {28'd0, n_uptime}, 1);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule